// File: doc/BRIEF.md
# Status Register Write-Protect Unit

This unit owns the protection state of a small serial non-volatile memory: a write enable latch, two block-protect bits that fence off part of the byte array, and a protect-enable bit that lets an external write-protect pin lock the status register. A command controller drives it with strobes to set or clear the latch, to commit a status write, and to commit an array write. The unit answers with two combinational permission flags, one for the array at the presented byte address and one for the status register. It also presents the status byte that a status read returns.

The protected region is always the top quarter, the top half or the whole of a `2**ADDR_W` byte array. Because of this, the same logic serves a 1024-byte part (`ADDR_W` = 10) and a 2048-byte part (`ADDR_W` = 11). The busy flag of the internal write cycle is passed straight through into the status byte.

Top module: `statusWriteGuard`

## Requirements
- R1: After reset the write enable latch, the protect-enable bit and both block-protect bits are 0. With `busyIn` low the status byte reads 0x00 and both permission flags are low.
- R2: The status byte is {protect-enable, 0, 0, 0, block-protect high, block-protect low, latch, busyIn}, with bit 7 first. Bit 0 follows `busyIn` in the same cycle.
- R3: A `setLatch` pulse sets the latch from the next cycle and a `clearLatch` pulse clears it, whatever the protection state. When both arrive in the same cycle, clear wins.
- R4: `arrayWrOk` is high only when the latch is 1 and `addrIn` is outside the protected region. Block-protect value 00 protects nothing. Value 01 protects addresses at or above 3/4 of the array (0x600 to 0x7FF for 2048 bytes), value 10 protects the top half (0x400 to 0x7FF), and value 11 protects every address.
- R5: `wpLevel` has no effect on `arrayWrOk`.
- R6: `statusWrOk` is high only when the latch is 1 and not (protect-enable is 1 and `wpLevel` is 0).
- R7: A `statusWrStrobe` while `statusWrOk` is high loads protect-enable from data bit 7 and block-protect from data bits 3:2. Data bits 6:4 and 1:0 are ignored. The latch clears in the next cycle.
- R8: A `statusWrStrobe` while `statusWrOk` is low changes nothing, and the latch keeps its value.
- R9: An `arrayWrStrobe` while `arrayWrOk` is high clears the latch. While `arrayWrOk` is low it leaves the latch unchanged.
- R10: A committed status or array write clears the latch even when `setLatch` arrives in the same cycle.
- R11: The stored protection bits change only on a committed status write. A later fall of `wpLevel` leaves a committed value untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busyIn | input | 1 | Internal write cycle in progress |
| wpLevel | input | 1 | Write-protect pin level, low means protect |
| addrIn | input | ADDR_W | Target byte address of an array write |
| setLatch | input | 1 | Set write enable latch |
| clearLatch | input | 1 | Clear write enable latch |
| statusWrStrobe | input | 1 | Commit a status register write |
| statusWrData | input | 8 | Byte offered for the status write |
| arrayWrStrobe | input | 1 | Commit an array write at `addrIn` |
| arrayWrOk | output | 1 | Array write permitted at `addrIn` |
| statusWrOk | output | 1 | Status register write permitted |
| statusByte | output | 8 | Status byte for reads |

## Verification
The properties assume that the controller raises each strobe for a single cycle. They also assume that `addrIn` and `wpLevel` are settled in a cycle where a commit strobe is high, so that the permission seen beside the strobe is the one that decides the commit. The bench changes inputs one time unit after a rising edge and holds every strobe for one cycle only. It reads the combinational flags before the next edge and reads registered state one edge after the stimulus.

// File: rtl/guardPkg.sv
package guardPkg;
  localparam int STAT_W = 8;
  localparam int WPEN_BIT = 7;
  localparam int BPHI_BIT = 3;
  localparam int BPLO_BIT = 2;
  localparam int WEL_BIT = 1;
  localparam int WIP_BIT = 0;

  typedef struct packed {
    logic welSet;
    logic welClr;
    logic statusLoad;
  } guardStb_t;
endpackage

// File: rtl/guardRegs.sv
module guardRegs
  import guardPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  guardStb_t         stb,
  input  logic [STAT_W-1:0] loadData,
  input  logic              busyIn,
  output logic              wel,
  output logic              wpen,
  output logic [1:0]        bp,
  output logic [STAT_W-1:0] statusByte
);
  logic unusedDataBits;
  assign unusedDataBits = ^{loadData[6:4], loadData[1:0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wel <= 1'b0;
    end else if (stb.welClr) begin
      wel <= 1'b0;
    end else if (stb.welSet) begin
      wel <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpen <= 1'b0;
      bp   <= 2'b00;
    end else if (stb.statusLoad) begin
      wpen <= loadData[WPEN_BIT];
      bp   <= loadData[BPHI_BIT:BPLO_BIT];
    end
  end

  always_comb begin
    statusByte = '0;
    statusByte[WPEN_BIT] = wpen;
    statusByte[BPHI_BIT:BPLO_BIT] = bp;
    statusByte[WEL_BIT] = wel;
    statusByte[WIP_BIT] = busyIn;
  end
endmodule

// File: rtl/guardCtrl.sv
module guardCtrl
  import guardPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              wel,
  input  logic              wpen,
  input  logic [1:0]        bp,
  input  logic              wpLevel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              setLatch,
  input  logic              clearLatch,
  input  logic              statusWrStrobe,
  input  logic              arrayWrStrobe,
  output logic              arrayOk,
  output logic              statusOk,
  output guardStb_t         stb
);
  localparam logic [ADDR_W-1:0] HALF_BASE = ADDR_W'(1) << (ADDR_W - 1);
  localparam logic [ADDR_W-1:0] QTR_BASE  = HALF_BASE | (ADDR_W'(1) << (ADDR_W - 2));

  logic [ADDR_W-1:0] fenceBase;
  logic              fenceOn;
  logic              inFence;
  logic              pinLock;
  logic              commit;

  always_comb begin
    case (bp)
      2'b01:   begin fenceOn = 1'b1; fenceBase = QTR_BASE;  end
      2'b10:   begin fenceOn = 1'b1; fenceBase = HALF_BASE; end
      2'b11:   begin fenceOn = 1'b1; fenceBase = '0;        end
      default: begin fenceOn = 1'b0; fenceBase = '0;        end
    endcase
  end

  assign inFence  = fenceOn && (addrIn >= fenceBase);
  assign pinLock  = wpen && !wpLevel;
  assign arrayOk  = wel && !inFence;
  assign statusOk = wel && !pinLock;
  assign commit   = (arrayWrStrobe && arrayOk) || (statusWrStrobe && statusOk);

  always_comb begin
    stb.welSet     = setLatch;
    stb.welClr     = clearLatch || commit;
    stb.statusLoad = statusWrStrobe && statusOk;
  end
endmodule

// File: rtl/statusWriteGuard.sv
module statusWriteGuard
  import guardPkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busyIn,
  input  logic              wpLevel,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              setLatch,
  input  logic              clearLatch,
  input  logic              statusWrStrobe,
  input  logic [7:0]        statusWrData,
  input  logic              arrayWrStrobe,
  output logic              arrayWrOk,
  output logic              statusWrOk,
  output logic [7:0]        statusByte
);
  guardStb_t  stb;
  logic       wel;
  logic       wpen;
  logic [1:0] bp;

  guardCtrl #(.ADDR_W(ADDR_W)) uCtrl (
    .wel(wel), .wpen(wpen), .bp(bp), .wpLevel(wpLevel), .addrIn(addrIn),
    .setLatch(setLatch), .clearLatch(clearLatch),
    .statusWrStrobe(statusWrStrobe), .arrayWrStrobe(arrayWrStrobe),
    .arrayOk(arrayWrOk), .statusOk(statusWrOk), .stb(stb)
  );

  guardRegs uRegs (
    .clk(clk), .rstN(rstN), .stb(stb), .loadData(statusWrData),
    .busyIn(busyIn), .wel(wel), .wpen(wpen), .bp(bp), .statusByte(statusByte)
  );
endmodule

// File: rtl/guardChecker.sv
module guardChecker #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rstN,
  input logic              busyIn,
  input logic              wpLevel,
  input logic [ADDR_W-1:0] addrIn,
  input logic              setLatch,
  input logic              clearLatch,
  input logic              statusWrStrobe,
  input logic [7:0]        statusWrData,
  input logic              arrayWrStrobe,
  input logic              arrayWrOk,
  input logic              statusWrOk,
  input logic [7:0]        statusByte
);
  logic commitSeen;
  assign commitSeen = (arrayWrStrobe && arrayWrOk) || (statusWrStrobe && statusWrOk);

  assert_layout_R2: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[6:4] == 3'b000 && statusByte[0] == busyIn);

  assert_latch_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    setLatch && !clearLatch && !commitSeen |=> statusByte[1]);

  assert_latch_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    clearLatch |=> !statusByte[1]);

  assert_array_needs_latch_R4: assert property (@(posedge clk) disable iff (!rstN)
    arrayWrOk |-> statusByte[1]);

  assert_all_fenced_R4: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[3:2] == 2'b11 |-> !arrayWrOk);

  assert_pin_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    statusByte[7] && !wpLevel |-> !statusWrOk);

  assert_commit_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    commitSeen |=> !statusByte[1]);

  assert_status_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    statusWrStrobe && statusWrOk |=>
      statusByte[7] == $past(statusWrData[7]) && statusByte[3:2] == $past(statusWrData[3:2]));

  assert_bits_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(statusWrStrobe && statusWrOk) |=> $stable(statusByte[7:2]));

  assert_refused_keeps_latch_R8: assert property (@(posedge clk) disable iff (!rstN)
    statusWrStrobe && !statusWrOk && !arrayWrStrobe && !clearLatch && statusByte[1] |=> statusByte[1]);
endmodule

bind statusWriteGuard guardChecker #(.ADDR_W(ADDR_W)) uChk (.*);

// File: tb/tb_statusWriteGuard.sv
module tb_statusWriteGuard;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 11;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busyIn = 1'b0;
  logic              wpLevel = 1'b1;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              setLatch = 1'b0;
  logic              clearLatch = 1'b0;
  logic              statusWrStrobe = 1'b0;
  logic [7:0]        statusWrData = '0;
  logic              arrayWrStrobe = 1'b0;
  logic              arrayWrOk;
  logic              statusWrOk;
  logic [7:0]        statusByte;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  statusWriteGuard #(.ADDR_W(ADDR_W)) dut (.*);

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic latchOn();
    setLatch = 1'b1; tick(); setLatch = 1'b0;
  endtask

  task automatic writeStatus(input logic [7:0] d);
    latchOn();
    statusWrData = d; statusWrStrobe = 1'b1; tick(); statusWrStrobe = 1'b0;
  endtask

  task automatic tReset();
    check("R1 status after reset", statusByte, 8'h00);
    check("R1 array flag after reset", {7'b0, arrayWrOk}, 8'h00);
    check("R1 status flag after reset", {7'b0, statusWrOk}, 8'h00);
    busyIn = 1'b1; #1;
    check("R2 busy in bit 0", statusByte, 8'h01);
    busyIn = 1'b0; #1;
  endtask

  task automatic tLatch();
    addrIn = 11'h7FF; #1;
    check("R4 no latch no array write", {7'b0, arrayWrOk}, 8'h00);
    latchOn();
    check("R3 latch set", statusByte, 8'h02);
    check("R4 bp00 top address open", {7'b0, arrayWrOk}, 8'h01);
    clearLatch = 1'b1; tick(); clearLatch = 1'b0;
    check("R3 latch cleared", statusByte, 8'h00);
    latchOn();
    setLatch = 1'b1; clearLatch = 1'b1; tick(); setLatch = 1'b0; clearLatch = 1'b0;
    check("R3 clear wins over set", statusByte, 8'h00);
  endtask

  task automatic tRanges();
    writeStatus(8'h04);
    check("R7 bp01 loaded latch cleared", statusByte, 8'h04);
    latchOn();
    addrIn = 11'h5FF; #1; check("R4 bp01 below quarter", {7'b0, arrayWrOk}, 8'h01);
    addrIn = 11'h600; #1; check("R4 bp01 at quarter", {7'b0, arrayWrOk}, 8'h00);
    wpLevel = 1'b0; #1;   check("R5 pin low no effect", {7'b0, arrayWrOk}, 8'h00);
    addrIn = 11'h5FF; #1; check("R5 pin low still open", {7'b0, arrayWrOk}, 8'h01);
    wpLevel = 1'b1;
    addrIn = 11'h7FF; arrayWrStrobe = 1'b1; tick(); arrayWrStrobe = 1'b0;
    check("R9 refused array write keeps latch", statusByte, 8'h06);
    addrIn = 11'h100; arrayWrStrobe = 1'b1; setLatch = 1'b1; tick();
    arrayWrStrobe = 1'b0; setLatch = 1'b0;
    check("R10 array commit beats set", statusByte, 8'h04);
    writeStatus(8'h08);
    latchOn();
    addrIn = 11'h3FF; #1; check("R4 bp10 below half", {7'b0, arrayWrOk}, 8'h01);
    addrIn = 11'h400; #1; check("R4 bp10 at half", {7'b0, arrayWrOk}, 8'h00);
    arrayWrStrobe = 1'b0; clearLatch = 1'b1; tick(); clearLatch = 1'b0;
    writeStatus(8'h0C);
    latchOn();
    addrIn = 11'h000; #1; check("R4 bp11 bottom fenced", {7'b0, arrayWrOk}, 8'h00);
    clearLatch = 1'b1; tick(); clearLatch = 1'b0;
  endtask

  task automatic tStatus();
    writeStatus(8'h73);
    check("R7 ignored data bits", statusByte, 8'h00);
    writeStatus(8'h80);
    check("R7 protect-enable loaded", statusByte, 8'h80);
    latchOn();
    wpLevel = 1'b0; #1;
    check("R6 pin lock blocks status", {7'b0, statusWrOk}, 8'h00);
    statusWrData = 8'h0C; statusWrStrobe = 1'b1; tick(); statusWrStrobe = 1'b0;
    check("R8 refused write no change", statusByte, 8'h82);
    wpLevel = 1'b1; #1;
    check("R6 pin high allows status", {7'b0, statusWrOk}, 8'h01);
    statusWrData = 8'h8C; statusWrStrobe = 1'b1; setLatch = 1'b1; tick();
    statusWrStrobe = 1'b0; setLatch = 1'b0;
    check("R10 status commit beats set", statusByte, 8'h8C);
    wpLevel = 1'b0; tick(); tick();
    check("R11 pin fall keeps stored bits", statusByte, 8'h8C);
    wpLevel = 1'b1;
    writeStatus(8'h00);
    check("R6 unlocked rewrite", statusByte, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1'b1;
    tick();
    tReset();
    tLatch();
    tRanges();
    tStatus();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule